// File: doc/BRIEF.md
# Write-Allocate Cache Fill Sequencer

This block sits between a store path and a data cache. Each store is presented with its address, 64-bit data, byte enables, a cacheable flag, an allocation-permitted flag and a hit flag from the cache lookup. A store that hits is accepted at once and left to the cache, which writes it and marks the line modified. A store that misses, is cacheable and may allocate does not go to the external bus as a write. Instead the block fetches the whole 32-byte line with a burst read and overlays the store bytes on the beat that holds them. It then presents the finished line to the cache fill port in the modified state.

Any other miss (non-cacheable, or allocation not permitted) goes out as one ordinary single-beat external write. The store port is held (ready low) from acceptance until the fill is installed or the write is acknowledged, so at most one operation is in flight.

Top module: `wa_fill_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, `st_ready` is 1 and `br_req`, `wr_req` and `fill_valid` are 0.
- R2: An accepted store with `st_hit`=0, `st_cacheable`=1 and `st_alloc_ok`=1 raises `br_req` on the next cycle with `br_addr` equal to the store address with its low 5 bits cleared, and `wr_req` stays 0 for the whole operation.
- R3: The burst returns four 64-bit beats in order, beat k carrying line bytes 8k to 8k+7. Cycles with `br_beat_valid`=0 between beats are allowed. `fill_valid` rises only on the cycle after the fourth beat is taken.
- R4: In the installed line, the beat selected by address bits [4:3] has byte i replaced by byte i of `st_data` wherever `st_be[i]`=1. All other bytes of the line equal the fetched data.
- R5: `fill_valid` lasts exactly one cycle. It carries `fill_index` = address bits [11:5], `fill_tag` = address bits [31:12] and `fill_state` = 2'b11 (modified).
- R6: An accepted store with `st_hit`=0 and either `st_cacheable`=0 or `st_alloc_ok`=0 raises `wr_req` on the next cycle with the store's address, data and byte enables unchanged. No burst read and no fill occur.
- R7: An accepted store with `st_hit`=1 causes no burst read, no external write and no fill, and `st_ready` stays 1.
- R8: `st_ready` is 0 from the cycle after acceptance of a miss until the cycle after `fill_valid` or after the `wr_ack` cycle.
- R9: `br_req` stays high with a stable address until `br_ack`, and `wr_req` stays high until `wr_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store request can be accepted |
| st_addr | input | 32 | Store byte address (8-byte aligned word) |
| st_data | input | 64 | Store data |
| st_be | input | 8 | Store byte enables |
| st_cacheable | input | 1 | Target is cacheable |
| st_alloc_ok | input | 1 | Allocation permitted for this address |
| st_hit | input | 1 | Line already present in the cache |
| br_req | output | 1 | Burst read request |
| br_addr | output | 32 | Line-aligned burst address |
| br_ack | input | 1 | Burst request accepted |
| br_beat_valid | input | 1 | Read beat present |
| br_beat_data | input | 64 | Read beat data |
| wr_req | output | 1 | Single external write request |
| wr_addr | output | 32 | Write address |
| wr_data | output | 64 | Write data |
| wr_be | output | 8 | Write byte enables |
| wr_ack | input | 1 | Write accepted |
| fill_valid | output | 1 | Line install strobe |
| fill_index | output | 7 | Cache set index |
| fill_tag | output | 20 | Cache tag |
| fill_data | output | 256 | Merged line, byte 0 in bits [7:0] |
| fill_state | output | 2 | Line state, 2'b11 modified |

## Verification
The merge is swept over every beat position and a set of byte-enable masks: all ones, none, single low and high bytes, and two mixed masks. These distinguish a wrong beat selection, a reversed byte order and an inverted enable. Alternate fills insert idle cycles between beats to separate beat counting from cycle counting, and the read request is stalled one cycle to expose a request that drops before acknowledgement. All eight combinations of the hit, cacheable and permitted flags are then applied to show that the routing to allocate, plain write or bypass follows the flags.

// File: rtl/wa_pkg.sv
package wa_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RDREQ,
    S_FILL,
    S_INSTALL,
    S_WRITE
  } seq_state_t;

  localparam logic [1:0] LINE_MODIFIED = 2'b11;
endpackage

// File: rtl/wa_byte_merge.sv
module wa_byte_merge #(
  parameter int DW = 64
) (
  input  logic            sel,
  input  logic [DW/8-1:0] be,
  input  logic [DW-1:0]   st_word,
  input  logic [DW-1:0]   rd_word,
  output logic [DW-1:0]   out_word
);
  localparam int BEW = DW / 8;

  for (genvar i = 0; i < BEW; i++) begin : g_byte
    assign out_word[i*8 +: 8] = (sel && be[i]) ? st_word[i*8 +: 8] : rd_word[i*8 +: 8];
  end
endmodule

// File: rtl/wa_line_buf.sv
module wa_line_buf #(
  parameter int DW    = 64,
  parameter int BEATS = 4,
  parameter int CW    = 2
) (
  input  logic                clk,
  input  logic                we,
  input  logic [CW-1:0]       idx,
  input  logic [DW-1:0]       wdata,
  output logic [DW*BEATS-1:0] line
);
  logic [DW-1:0] mem [BEATS];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  for (genvar k = 0; k < BEATS; k++) begin : g_rd
    assign line[k*DW +: DW] = mem[k];
  end
endmodule

// File: rtl/wa_seq_ctrl.sv
module wa_seq_ctrl
  import wa_pkg::*;
#(
  parameter int BEATS = 4,
  parameter int CW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          st_valid,
  input  logic          st_cacheable,
  input  logic          st_alloc_ok,
  input  logic          st_hit,
  input  logic          br_ack,
  input  logic          br_beat_valid,
  input  logic          wr_ack,
  output logic          st_ready,
  output logic          cap_en,
  output logic          br_req,
  output logic          wr_req,
  output logic          fill_valid,
  output logic          beat_we,
  output logic [CW-1:0] beat_idx
);
  localparam logic [CW-1:0] LAST = CW'(BEATS - 1);

  seq_state_t    state;
  logic [CW-1:0] cnt;

  assign st_ready   = (state == S_IDLE);
  assign cap_en     = st_valid && st_ready;
  assign br_req     = (state == S_RDREQ);
  assign wr_req     = (state == S_WRITE);
  assign fill_valid = (state == S_INSTALL);
  assign beat_we    = (state == S_FILL) && br_beat_valid;
  assign beat_idx   = cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (st_valid) begin
          if (st_hit)                           state <= S_IDLE;
          else if (st_cacheable && st_alloc_ok) state <= S_RDREQ;
          else                                  state <= S_WRITE;
        end
        S_RDREQ: if (br_ack) begin
          state <= S_FILL;
          cnt   <= '0;
        end
        S_FILL: if (br_beat_valid) begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= S_INSTALL;
        end
        S_INSTALL: state <= S_IDLE;
        S_WRITE:   if (wr_ack) state <= S_IDLE;
        default:   state <= S_IDLE;
      endcase
    end
  end

  // R2
  alloc_read_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_en && !st_hit && st_cacheable && st_alloc_ok) |=> (br_req && !wr_req));
  // R6
  plain_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_en && !st_hit && !(st_cacheable && st_alloc_ok)) |=> (wr_req && !br_req));
  // R7
  hit_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_en && st_hit) |=> (st_ready && !br_req && !wr_req && !fill_valid));
  // R9
  rdreq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (br_req && !br_ack) |=> br_req);
  // R9
  wrreq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_ack) |=> wr_req);
  // R5
  fill_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> (!fill_valid && st_ready));
  // R3
  install_after_beat_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fill_valid) |-> $past(br_beat_valid));
endmodule

// File: rtl/wa_fill_seq.sv
module wa_fill_seq
  import wa_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 64,
  parameter int LINE_BYTES = 32,
  parameter int IDXW       = 7
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     st_valid,
  output logic                     st_ready,
  input  logic [AW-1:0]            st_addr,
  input  logic [DW-1:0]            st_data,
  input  logic [DW/8-1:0]          st_be,
  input  logic                     st_cacheable,
  input  logic                     st_alloc_ok,
  input  logic                     st_hit,
  output logic                     br_req,
  output logic [AW-1:0]            br_addr,
  input  logic                     br_ack,
  input  logic                     br_beat_valid,
  input  logic [DW-1:0]            br_beat_data,
  output logic                     wr_req,
  output logic [AW-1:0]            wr_addr,
  output logic [DW-1:0]            wr_data,
  output logic [DW/8-1:0]          wr_be,
  input  logic                     wr_ack,
  output logic                     fill_valid,
  output logic [IDXW-1:0]          fill_index,
  output logic [AW-IDXW-$clog2(LINE_BYTES)-1:0] fill_tag,
  output logic [LINE_BYTES*8-1:0]  fill_data,
  output logic [1:0]               fill_state
);
  localparam int BEW   = DW / 8;
  localparam int BEATS = LINE_BYTES * 8 / DW;
  localparam int OFFW  = $clog2(LINE_BYTES);
  localparam int WOFF  = $clog2(BEW);
  localparam int CW    = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [AW-1:0]  a_q;
  logic [DW-1:0]  d_q;
  logic [BEW-1:0] be_q;
  logic           cap_en, beat_we;
  logic [CW-1:0]  beat_idx;
  logic [DW-1:0]  merged;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q  <= '0;
      d_q  <= '0;
      be_q <= '0;
    end else if (cap_en) begin
      a_q  <= st_addr;
      d_q  <= st_data;
      be_q <= st_be;
    end
  end

  wa_seq_ctrl #(.BEATS(BEATS), .CW(CW)) ctrl_i (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_cacheable(st_cacheable),
    .st_alloc_ok(st_alloc_ok), .st_hit(st_hit), .br_ack(br_ack),
    .br_beat_valid(br_beat_valid), .wr_ack(wr_ack), .st_ready(st_ready),
    .cap_en(cap_en), .br_req(br_req), .wr_req(wr_req), .fill_valid(fill_valid),
    .beat_we(beat_we), .beat_idx(beat_idx)
  );

  wa_byte_merge #(.DW(DW)) merge_i (
    .sel(beat_idx == CW'(a_q[OFFW-1:WOFF])), .be(be_q), .st_word(d_q),
    .rd_word(br_beat_data), .out_word(merged)
  );

  wa_line_buf #(.DW(DW), .BEATS(BEATS), .CW(CW)) buf_i (
    .clk(clk), .we(beat_we), .idx(beat_idx), .wdata(merged), .line(fill_data)
  );

  assign br_addr    = {a_q[AW-1:OFFW], {OFFW{1'b0}}};
  assign wr_addr    = a_q;
  assign wr_data    = d_q;
  assign wr_be      = be_q;
  assign fill_index = a_q[OFFW+IDXW-1:OFFW];
  assign fill_tag   = a_q[AW-1:OFFW+IDXW];
  assign fill_state = LINE_MODIFIED;

  // R8
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (br_req || wr_req || beat_we) |-> !st_ready);
  // R9
  rdaddr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (br_req && !br_ack) |=> $stable(br_addr));
endmodule

// File: tb/wa_fill_seq_tb.sv
module wa_fill_seq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic         st_valid = 0, st_cacheable = 0, st_alloc_ok = 0, st_hit = 0;
  logic [31:0]  st_addr = 0;
  logic [63:0]  st_data = 0;
  logic [7:0]   st_be = 0;
  logic         br_ack = 0, br_beat_valid = 0, wr_ack = 0;
  logic [63:0]  br_beat_data = 0;
  logic         st_ready, br_req, wr_req, fill_valid;
  logic [31:0]  br_addr, wr_addr;
  logic [63:0]  wr_data;
  logic [7:0]   wr_be;
  logic [6:0]   fill_index;
  logic [19:0]  fill_tag;
  logic [255:0] fill_data;
  logic [1:0]   fill_state;

  int checks = 0;
  int errors = 0;

  wa_fill_seq dut_i (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .st_cacheable(st_cacheable), .st_alloc_ok(st_alloc_ok), .st_hit(st_hit),
    .br_req(br_req), .br_addr(br_addr), .br_ack(br_ack),
    .br_beat_valid(br_beat_valid), .br_beat_data(br_beat_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
    .wr_ack(wr_ack), .fill_valid(fill_valid), .fill_index(fill_index),
    .fill_tag(fill_tag), .fill_data(fill_data), .fill_state(fill_state)
  );

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] beat_pat(input int b, input logic [31:0] a);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[i*8 +: 8] = 8'((b * 37) ^ (i * 11) ^ a[12:5] ^ 8'h5A);
    return r;
  endfunction

  function automatic logic [63:0] st_pat(input logic [31:0] a);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[i*8 +: 8] = 8'(8'hC1 + i * 3 + a[4:3]);
    return r;
  endfunction

  task automatic offer(input logic [31:0] a, input logic [7:0] be,
                       input logic c, input logic ok, input logic h);
    @(negedge clk);
    st_valid = 1; st_addr = a; st_data = st_pat(a); st_be = be;
    st_cacheable = c; st_alloc_ok = ok; st_hit = h;
    @(negedge clk);
    st_valid = 0;
  endtask

  task automatic run_alloc(input logic [31:0] a, input logic [7:0] be, input bit gap);
    logic [255:0] exp;
    logic [63:0]  sd;
    sd = st_pat(a);
    offer(a, be, 1'b1, 1'b1, 1'b0);
    check("R2 br_req", 256'(br_req), 256'(1));
    check("R2 br_addr", 256'(br_addr), 256'(a & 32'hFFFF_FFE0));
    check("R2 no write", 256'(wr_req), 256'(0));
    check("R8 ready low", 256'(st_ready), 256'(0));
    @(negedge clk);
    check("R9 br_req held", 256'(br_req), 256'(1));
    br_ack = 1;
    @(negedge clk);
    br_ack = 0;
    for (int b = 0; b < 4; b++) begin
      br_beat_valid = 1; br_beat_data = beat_pat(b, a);
      @(negedge clk);
      if (gap && b < 3) begin
        br_beat_valid = 0;
        check("R3 no early fill", 256'(fill_valid), 256'(0));
        @(negedge clk);
      end
    end
    br_beat_valid = 0;
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < 8; i++)
        exp[b*64 + i*8 +: 8] = (b == int'(a[4:3]) && be[i]) ? sd[i*8 +: 8]
                                                           : beat_pat(b, a) >> (i*8);
    check("R3 fill after 4th beat", 256'(fill_valid), 256'(1));
    check("R4 merged line", fill_data, exp);
    check("R5 index", 256'(fill_index), 256'(a[11:5]));
    check("R5 tag", 256'(fill_tag), 256'(a[31:12]));
    check("R5 state modified", 256'(fill_state), 256'(2'b11));
    check("R2 no write during fill", 256'(wr_req), 256'(0));
    @(negedge clk);
    check("R5 single pulse", 256'(fill_valid), 256'(0));
    check("R8 ready back", 256'(st_ready), 256'(1));
  endtask

  task automatic run_write(input logic [31:0] a, input logic [7:0] be, input logic c, input logic ok);
    offer(a, be, c, ok, 1'b0);
    check("R6 wr_req", 256'(wr_req), 256'(1));
    check("R6 wr_addr", 256'(wr_addr), 256'(a));
    check("R6 wr_data", 256'(wr_data), 256'(st_pat(a)));
    check("R6 wr_be", 256'(wr_be), 256'(be));
    check("R6 no read", 256'(br_req), 256'(0));
    check("R8 ready low", 256'(st_ready), 256'(0));
    @(negedge clk);
    check("R9 wr_req held", 256'(wr_req), 256'(1));
    wr_ack = 1;
    @(negedge clk);
    wr_ack = 0;
    check("R6 write done", 256'(wr_req), 256'(0));
    check("R6 no fill", 256'(fill_valid), 256'(0));
    check("R8 ready back", 256'(st_ready), 256'(1));
  endtask

  task automatic run_hit(input logic [31:0] a, input logic c, input logic ok);
    offer(a, 8'hFF, c, ok, 1'b1);
    check("R7 no read", 256'(br_req), 256'(0));
    check("R7 no write", 256'(wr_req), 256'(0));
    check("R7 ready", 256'(st_ready), 256'(1));
    @(negedge clk);
    check("R7 no fill", 256'(fill_valid), 256'(0));
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] masks [6];
    masks[0] = 8'hFF; masks[1] = 8'h00; masks[2] = 8'h01;
    masks[3] = 8'h80; masks[4] = 8'hA5; masks[5] = 8'h3C;
    repeat (3) @(negedge clk);
    check("R1 ready in reset", 256'(st_ready), 256'(1));
    check("R1 no read in reset", 256'(br_req), 256'(0));
    check("R1 no write in reset", 256'(wr_req), 256'(0));
    check("R1 no fill in reset", 256'(fill_valid), 256'(0));
    rst = 0;
    @(negedge clk);
    check("R1 ready after reset", 256'(st_ready), 256'(1));
    for (int w = 0; w < 4; w++)
      for (int m = 0; m < 6; m++)
        run_alloc(32'h0123_4000 + 32'(m) * 32'h0000_1060 + 32'(w * 8), masks[m], w[0]);
    for (int c = 0; c < 8; c++) begin
      logic [31:0] a;
      a = 32'h8765_4318 + 32'(c) * 32'h40;
      if (c[2])               run_hit(a, c[0], c[1]);
      else if (c[0] && c[1])  run_alloc(a, 8'h5A, 1'b0);
      else                    run_write(a, 8'h0F << c, c[0], c[1]);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule